// File: doc/BRIEF.md
# Scatter-Gather Descriptor Pointer Unit

This unit keeps the current descriptor pointer for one direction of a scatter-gather DMA channel. When the controller asks for a load, it reads a 16-byte descriptor over a word-wide memory read port. It unpacks the descriptor into a buffer address, a byte count and control bits. Afterwards it moves the pointer on to the next descriptor in the chain.

The type bit of each descriptor selects how the pointer moves. A sequential descriptor moves the pointer forward by one descriptor length. A chained descriptor takes the next pointer from a 64-bit link word stored just past the descriptor. In register mode the descriptor comes from a programmed 128-bit input and memory is not touched. The destination direction advances by itself right after each fetch. The source direction waits for an explicit advance request.

The memory read port is valid/ready on both channels:
- A request (`rd_valid`, `rd_addr`) stays stable until `rd_ready` is seen.
- A response is taken in any cycle where `rd_rsp_valid` and `rd_rsp_ready` are both high.
- Only one read is outstanding at a time.

Misaligned pointers and memory response errors both zero the unpacked fields, pulse `rd_err` and set a sticky error flag.

Top module: `dptr_unit`

## Requirements
- R1: After reset the pointer, every unpacked field, `err_sticky`, `busy`, `rd_valid` and all pulses are zero.
- R2: A `preload` pulse while idle loads the pointer from `start_hi`/`start_lo`. Only bits 16:0 of `start_hi` are kept, and `ptr_hi` bits 31:17 read zero. The same pulse clears `err_sticky`. While busy, `preload` is ignored.
- R3: A memory load issues word reads at pointer+0, +4, +8 and +12, in that order, and then pulses `fetch_done`. The fields are unpacked as follows: word0 is buffer address bits 31:0; word1 bits 16:0 are address bits 48:32; word2 bits 29:0 are the byte size; word3 bit0 is coherent, bit1 is type, bit2 is interrupt, and bits 4:3 are the command.
- R4: A load with pointer bits 3:0 non-zero performs no memory read. It zeroes the fields, pulses `rd_err` once and sets `err_sticky`.
- R5: A response with `rd_rsp_err` set, on a descriptor read or a link read, ends the operation. It zeroes the fields, pulses `rd_err`, sets `err_sticky` and leaves the pointer unchanged.
- R6: Advancing with type 0 sets the pointer to pointer+16 without any memory read, and pulses `adv_done`.
- R7: Advancing with type 1 reads pointer+16 (low word) and then pointer+20 (high word). The pointer becomes {high[16:0], low} only after both reads complete, and stays unchanged while they are in flight.
- R8: In register mode a load takes the fields from `reg_words` (word0 in bits 31:0, up to word3 in bits 127:96). It pulses `fetch_done` the next cycle, performs no memory read and never advances.
- R9: With `dir_dst` high, a memory load is followed at once by an advance that uses the type just fetched. With `dir_dst` low, the pointer moves only on `advance_req`, which uses the type of the last fetch.
- R10: A read request holds `rd_valid` and `rd_addr` stable until `rd_ready`, and each word is requested exactly once.
- R11: `fetch_done`, `adv_done` and `rd_err` are single-cycle pulses. One load gives at most one `fetch_done`, and `fetch_done` and `rd_err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_dst | input | 1 | 1: destination side (auto-advance after fetch) |
| reg_mode | input | 1 | 1: descriptor comes from `reg_words` |
| reg_words | input | 128 | Programmed descriptor, word0 in low bits |
| preload | input | 1 | Load pointer from start inputs |
| start_lo | input | 32 | Start pointer bits 31:0 |
| start_hi | input | 32 | Start pointer bits 63:32 (16:0 kept) |
| load_req | input | 1 | Fetch descriptor at pointer |
| advance_req | input | 1 | Move pointer to next descriptor |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 49 | Read byte address (word aligned) |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_ready | output | 1 | Unit can take a response |
| rd_rsp_data | input | 32 | Read response word |
| rd_rsp_err | input | 1 | Read response error |
| busy | output | 1 | Operation in progress |
| ptr_lo | output | 32 | Pointer bits 31:0 |
| ptr_hi | output | 32 | Pointer bits 48:32, upper bits zero |
| buf_addr | output | 49 | Unpacked buffer address |
| byte_size | output | 30 | Unpacked byte count |
| dsc_coherent | output | 1 | Unpacked coherent bit |
| dsc_type | output | 1 | Unpacked type (0 sequential, 1 chained) |
| dsc_intr | output | 1 | Unpacked interrupt bit |
| dsc_cmd | output | 2 | Unpacked command |
| fetch_done | output | 1 | Pulse: descriptor fields updated |
| adv_done | output | 1 | Pulse: pointer advanced |
| rd_err | output | 1 | Pulse: misalignment or read error |
| err_sticky | output | 1 | Error seen since last preload |

## Verification
Two situations are hard to reach from the ports. The first is a link-word read that fails after the descriptor itself arrived cleanly. In that case one load must give both a `fetch_done` and a later `rd_err`, and the pointer must stay where it was. The bench reaches it by running the destination side over a chained descriptor while the memory model flags an error on exactly the link word's index. The second is a request held across refused cycles. The memory model drops `rd_ready` on a repeating pattern through every sweep. The exact read address log per load shows that no word is dropped or requested twice.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int DSC_WORDS = 4;
  localparam int DSC_BYTES = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} dptr_st_e;
  typedef enum logic {OP_FETCH, OP_LINK} dptr_op_e;
endpackage

// File: rtl/dptr_unpack.sv
module dptr_unpack #(
  parameter int ADDR_W = 49,
  parameter int SIZE_W = 30,
  parameter int WORD_W = 32
) (
  input  logic [4*WORD_W-1:0] words,
  output logic [ADDR_W-1:0]   addr,
  output logic [SIZE_W-1:0]   size,
  output logic                coh,
  output logic                typ,
  output logic                intr,
  output logic [1:0]          cmd
);
  localparam int HI_W = ADDR_W - WORD_W;

  logic [WORD_W-1:0] w0, w1, w2, w3;
  logic              unused_rsvd;

  assign w0 = words[0*WORD_W +: WORD_W];
  assign w1 = words[1*WORD_W +: WORD_W];
  assign w2 = words[2*WORD_W +: WORD_W];
  assign w3 = words[3*WORD_W +: WORD_W];

  assign addr = {w1[HI_W-1:0], w0};
  assign size = w2[SIZE_W-1:0];
  assign coh  = w3[0];
  assign typ  = w3[1];
  assign intr = w3[2];
  assign cmd  = w3[4:3];

  // reserved bits of the descriptor words are dropped
  assign unused_rsvd = ^{w1[WORD_W-1:HI_W], w2[WORD_W-1:SIZE_W], w3[WORD_W-1:5]};
endmodule

// File: rtl/dptr_ptr_reg.sv
module dptr_ptr_reg #(
  parameter int ADDR_W = 49,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic [WORD_W-1:0] set_lo,
  input  logic [WORD_W-1:0] set_hi,
  input  logic              upd,
  input  logic [ADDR_W-1:0] upd_val,
  output logic [ADDR_W-1:0] ptr
);
  localparam int HI_W = ADDR_W - WORD_W;

  logic unused_hi;
  assign unused_hi = ^set_hi[WORD_W-1:HI_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (set) ptr <= {set_hi[HI_W-1:0], set_lo};
    else if (upd) ptr <= upd_val;
  end
endmodule

// File: rtl/dptr_unit.sv
module dptr_unit
  import dptr_pkg::*;
#(
  parameter int ADDR_W = 49,
  parameter int SIZE_W = 30,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dir_dst,
  input  logic                reg_mode,
  input  logic [4*WORD_W-1:0] reg_words,
  input  logic                preload,
  input  logic [WORD_W-1:0]   start_lo,
  input  logic [WORD_W-1:0]   start_hi,
  input  logic                load_req,
  input  logic                advance_req,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic                rd_rsp_valid,
  output logic                rd_rsp_ready,
  input  logic [WORD_W-1:0]   rd_rsp_data,
  input  logic                rd_rsp_err,
  output logic                busy,
  output logic [WORD_W-1:0]   ptr_lo,
  output logic [WORD_W-1:0]   ptr_hi,
  output logic [ADDR_W-1:0]   buf_addr,
  output logic [SIZE_W-1:0]   byte_size,
  output logic                dsc_coherent,
  output logic                dsc_type,
  output logic                dsc_intr,
  output logic [1:0]          dsc_cmd,
  output logic                fetch_done,
  output logic                adv_done,
  output logic                rd_err,
  output logic                err_sticky
);
  localparam int HI_W  = ADDR_W - WORD_W;
  localparam int PAD_W = 2*WORD_W - ADDR_W;
  localparam logic [1:0] LAST_W = 2'(DSC_WORDS - 1);

  dptr_st_e          st;
  dptr_op_e          op;
  logic [1:0]        idx;
  logic [WORD_W-1:0] wb0, wb1, wb2, link_lo;
  logic [ADDR_W-1:0] ptr, ptr_nxt;
  logic              ptr_upd, ptr_set;
  logic [4:0]        ofs;
  logic              rsp_ok, rsp_bad, last_fetch;

  logic [4*WORD_W-1:0] unp_words;
  logic [ADDR_W-1:0]   u_addr;
  logic [SIZE_W-1:0]   u_size;
  logic                u_coh, u_typ, u_intr;
  logic [1:0]          u_cmd;

  assign busy         = (st != ST_IDLE);
  assign rd_valid     = (st == ST_REQ);
  assign rd_rsp_ready = (st == ST_RSP);
  assign ofs          = {op == OP_LINK, idx, 2'b00};
  assign rd_addr      = ptr + ADDR_W'(ofs);
  assign ptr_lo       = ptr[WORD_W-1:0];
  assign ptr_hi       = {{PAD_W{1'b0}}, ptr[ADDR_W-1:WORD_W]};
  assign ptr_set      = preload && (st == ST_IDLE);
  assign rsp_ok       = (st == ST_RSP) && rd_rsp_valid && !rd_rsp_err;
  assign rsp_bad      = (st == ST_RSP) && rd_rsp_valid && rd_rsp_err;
  assign last_fetch   = rsp_ok && (op == OP_FETCH) && (idx == LAST_W);

  // Idle: the programmed words; fetching: the three buffered words plus the arriving one
  assign unp_words = (st == ST_IDLE) ? reg_words : {rd_rsp_data, wb2, wb1, wb0};

  dptr_unpack #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WORD_W(WORD_W)) u_unpack (
    .words(unp_words), .addr(u_addr), .size(u_size),
    .coh(u_coh), .typ(u_typ), .intr(u_intr), .cmd(u_cmd)
  );

  always_comb begin
    ptr_upd = 1'b0;
    ptr_nxt = ptr + ADDR_W'(DSC_BYTES);
    if (st == ST_IDLE && !preload && !load_req && advance_req && !dsc_type)
      ptr_upd = 1'b1;
    if (last_fetch && dir_dst && !rd_rsp_data[1])
      ptr_upd = 1'b1;
    if (rsp_ok && op == OP_LINK && idx[0]) begin
      ptr_upd = 1'b1;
      ptr_nxt = {rd_rsp_data[HI_W-1:0], link_lo};
    end
  end

  dptr_ptr_reg #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .set(ptr_set), .set_lo(start_lo), .set_hi(start_hi),
    .upd(ptr_upd), .upd_val(ptr_nxt), .ptr(ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  op <= OP_FETCH;  idx <= '0;
      wb0 <= '0;  wb1 <= '0;  wb2 <= '0;  link_lo <= '0;
      buf_addr <= '0;  byte_size <= '0;
      dsc_coherent <= 1'b0;  dsc_type <= 1'b0;  dsc_intr <= 1'b0;  dsc_cmd <= '0;
      fetch_done <= 1'b0;  adv_done <= 1'b0;  rd_err <= 1'b0;  err_sticky <= 1'b0;
    end else begin
      fetch_done <= 1'b0;
      adv_done   <= 1'b0;
      rd_err     <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (preload) begin
            err_sticky <= 1'b0;
          end else if (load_req) begin
            if (reg_mode) begin
              buf_addr <= u_addr;  byte_size <= u_size;
              dsc_coherent <= u_coh;  dsc_type <= u_typ;  dsc_intr <= u_intr;  dsc_cmd <= u_cmd;
              fetch_done <= 1'b1;
            end else if (ptr[3:0] != 4'h0) begin
              buf_addr <= '0;  byte_size <= '0;
              dsc_coherent <= 1'b0;  dsc_type <= 1'b0;  dsc_intr <= 1'b0;  dsc_cmd <= '0;
              rd_err <= 1'b1;  err_sticky <= 1'b1;
            end else begin
              op <= OP_FETCH;  idx <= '0;  st <= ST_REQ;
            end
          end else if (advance_req) begin
            if (dsc_type) begin
              op <= OP_LINK;  idx <= '0;  st <= ST_REQ;
            end else begin
              adv_done <= 1'b1;
            end
          end
        end
        ST_REQ: if (rd_ready) st <= ST_RSP;
        ST_RSP: begin
          if (rsp_bad) begin
            buf_addr <= '0;  byte_size <= '0;
            dsc_coherent <= 1'b0;  dsc_type <= 1'b0;  dsc_intr <= 1'b0;  dsc_cmd <= '0;
            rd_err <= 1'b1;  err_sticky <= 1'b1;  st <= ST_IDLE;
          end else if (rsp_ok) begin
            if (op == OP_FETCH) begin
              case (idx)
                2'd0:    wb0 <= rd_rsp_data;
                2'd1:    wb1 <= rd_rsp_data;
                2'd2:    wb2 <= rd_rsp_data;
                default: ;
              endcase
              if (last_fetch) begin
                buf_addr <= u_addr;  byte_size <= u_size;
                dsc_coherent <= u_coh;  dsc_type <= u_typ;  dsc_intr <= u_intr;  dsc_cmd <= u_cmd;
                fetch_done <= 1'b1;
                if (dir_dst && u_typ) begin
                  op <= OP_LINK;  idx <= '0;  st <= ST_REQ;
                end else begin
                  adv_done <= dir_dst;
                  st <= ST_IDLE;
                end
              end else begin
                idx <= idx + 2'd1;  st <= ST_REQ;
              end
            end else if (!idx[0]) begin
              link_lo <= rd_rsp_data;  idx <= 2'd1;  st <= ST_REQ;
            end else begin
              adv_done <= 1'b1;  st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dptr_unit_chk.sv
module dptr_unit_chk #(
  parameter int ADDR_W = 49,
  parameter int SIZE_W = 30,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              busy,
  input logic [WORD_W-1:0] ptr_lo,
  input logic [WORD_W-1:0] ptr_hi,
  input logic [ADDR_W-1:0] buf_addr,
  input logic [SIZE_W-1:0] byte_size,
  input logic              fetch_done,
  input logic              rd_err,
  input logic              err_sticky
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  p_word_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_addr[1:0] == 2'b00);

  p_err_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (buf_addr == '0 && byte_size == '0 && err_sticky));

  p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_done && rd_err));

  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy -> $stable({ptr_hi, ptr_lo})));
endmodule

bind dptr_unit dptr_unit_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .busy(busy), .ptr_lo(ptr_lo), .ptr_hi(ptr_hi), .buf_addr(buf_addr), .byte_size(byte_size),
  .fetch_done(fetch_done), .rd_err(rd_err), .err_sticky(err_sticky)
);

// File: tb/dptr_unit_bench.sv
module dptr_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dir_dst = 1'b0, reg_mode = 1'b0;
  logic [127:0] reg_words = '0;
  logic         preload = 1'b0, load_req = 1'b0, advance_req = 1'b0;
  logic [31:0]  start_lo = '0, start_hi = '0;
  logic         rd_valid, rd_ready = 1'b0, rd_rsp_ready, busy;
  logic [48:0]  rd_addr, buf_addr;
  logic         rd_rsp_valid = 1'b0, rd_rsp_err = 1'b0;
  logic [31:0]  rd_rsp_data = '0, ptr_lo, ptr_hi;
  logic [29:0]  byte_size;
  logic         dsc_coherent, dsc_type, dsc_intr, fetch_done, adv_done, rd_err, err_sticky;
  logic [1:0]   dsc_cmd;

  always #2 clk = ~clk;

  dptr_unit u_dptr_unit (
    .clk(clk), .rst_n(rst_n), .dir_dst(dir_dst), .reg_mode(reg_mode), .reg_words(reg_words),
    .preload(preload), .start_lo(start_lo), .start_hi(start_hi), .load_req(load_req),
    .advance_req(advance_req), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .rd_rsp_err(rd_rsp_err), .busy(busy), .ptr_lo(ptr_lo), .ptr_hi(ptr_hi),
    .buf_addr(buf_addr), .byte_size(byte_size), .dsc_coherent(dsc_coherent),
    .dsc_type(dsc_type), .dsc_intr(dsc_intr), .dsc_cmd(dsc_cmd), .fetch_done(fetch_done),
    .adv_done(adv_done), .rd_err(rd_err), .err_sticky(err_sticky)
  );

  // memory model: 256 words, throttled request acceptance, error on one word index
  logic [31:0] mem [0:255];
  logic [48:0] rd_log [0:15];
  int          n_rd = 0, err_idx = -1;
  logic [3:0]  bp_cnt = '0;

  always @(posedge clk) begin
    bp_cnt   <= bp_cnt + 4'd1;
    rd_ready <= (bp_cnt[1:0] != 2'd0);
    if (rd_valid && rd_ready) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= mem[rd_addr[9:2]];
      rd_rsp_err   <= (int'(rd_addr[9:2]) == err_idx);
      rd_log[n_rd % 16] <= rd_addr;
      n_rd <= n_rd + 1;
    end else if (rd_rsp_valid && rd_rsp_ready) begin
      rd_rsp_valid <= 1'b0;
    end
  end

  int n_done = 0, n_adv = 0, n_err = 0;
  always @(negedge clk) begin
    if (fetch_done) n_done++;
    if (adv_done)   n_adv++;
    if (rd_err)     n_err++;
  end

  int checks = 0, errors = 0;
  int b_rd, b_done, b_adv, b_err;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic snap();
    b_rd = n_rd; b_done = n_done; b_adv = n_adv; b_err = n_err;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 2000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic do_preload(input logic [31:0] lo, input logic [31:0] hi);
    @(negedge clk); preload = 1'b1; start_lo = lo; start_hi = hi;
    @(negedge clk); preload = 1'b0;
  endtask

  task automatic do_load();
    snap();
    @(negedge clk); load_req = 1'b1;
    @(negedge clk); load_req = 1'b0;
    wait_idle();
  endtask

  task automatic do_adv();
    snap();
    @(negedge clk); advance_req = 1'b1;
    @(negedge clk); advance_req = 1'b0;
    wait_idle();
  endtask

  function automatic logic [127:0] mk_desc(input int k, input logic force_type, input logic tval);
    logic [31:0] w0, w1, w2, w3;
    w0 = 32'h8000_0000 ^ (k * 32'h0102_0304);
    w1 = 32'hFFFE_0000 | ((k * 32'h0000_1111) & 32'h0001_FFFF);
    w2 = 32'hC000_0000 | ((k * 32'h0123_4567) & 32'h3FFF_FFFF);
    w3 = 32'hFFFF_FFE0 | ((k * 5) & 32'h1D);
    if (force_type) w3[1] = tval;
    return {w3, w2, w1, w0};
  endfunction

  task automatic put_desc(input int word, input logic [127:0] d);
    for (int i = 0; i < 4; i++) mem[word + i] = d[32*i +: 32];
  endtask

  task automatic chk_fields(input string req, input logic [127:0] d);
    chk(req, {15'b0, buf_addr}, {15'b0, d[48:32], d[31:0]});
    chk(req, {34'b0, byte_size}, {34'b0, d[93:64]});
    chk(req, {59'b0, dsc_cmd, dsc_intr, dsc_type, dsc_coherent}, {59'b0, d[100:96]});
  endtask

  task automatic chk_reads(input string req, input int n, input logic [48:0] base, input int lnk);
    chk(req, 64'(n_rd - b_rd), 64'(n));
    for (int i = 0; i < n; i++)
      chk(req, {15'b0, rd_log[(b_rd + i) % 16]},
          {15'b0, base + 49'((i < 4 && lnk == 0) ? 4*i : (lnk ? 16 + 4*i : 16 + 4*(i-4)))});
  endtask

  function automatic logic [63:0] ptr64();
    return {ptr_hi, ptr_lo};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] d;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    for (int k = 0; k < 24; k++) put_desc(4*k, mk_desc(k, 1'b1, 1'b0));
    for (int j = 0; j < 8; j++) begin
      put_desc(128 + 8*j, mk_desc(100 + j, 1'b1, 1'b1));
      mem[128 + 8*j + 4] = 32'h200 + 32'((j*3 + 1) % 8) * 32;
      mem[128 + 8*j + 5] = 32'hFFFE_0000;
    end

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", ptr64(), 64'h0);
    chk("R1", {15'b0, buf_addr}, 64'h0);
    chk("R1", {60'b0, err_sticky, busy, rd_valid, fetch_done | adv_done | rd_err}, 64'h0);
    rst_n = 1'b1;

    // R2 preload masks high word
    do_preload(32'h1234_5670, 32'hFFFF_FFFF);
    chk("R2", ptr64(), 64'h0001_FFFF_1234_5670);

    // R3 R6 R9 R10 R11 source side linear sweep
    dir_dst = 1'b0;
    do_preload(32'h0, 32'h0);
    for (int k = 0; k < 24; k++) begin
      d = mk_desc(k, 1'b1, 1'b0);
      do_load();
      chk_fields("R3", d);
      chk_reads("R3 R10", 4, 49'(16*k), 0);
      chk("R9 source holds pointer", ptr64(), 64'(16*k));
      chk("R11 one fetch_done", 64'(n_done - b_done), 64'd1);
      do_adv();
      chk("R6", ptr64(), 64'(16*(k+1)));
      chk("R6 no read", 64'(n_rd - b_rd), 64'd0);
    end

    // R7 R9 destination side chained walk
    dir_dst = 1'b1;
    do_preload(32'h200, 32'h0);
    begin
      int j = 0;
      for (int s = 0; s < 8; s++) begin
        d = mk_desc(100 + j, 1'b1, 1'b1);
        do_load();
        chk_fields("R9 dst fetch", d);
        chk_reads("R7 R10", 6, 49'(32'h200 + 32*j), 0);
        j = (j*3 + 1) % 8;
        chk("R7 R9 link pointer", ptr64(), 64'(32'h200 + 32*j));
        chk("R11 adv pulses", 64'(n_adv - b_adv), 64'd1);
      end
    end

    // R7 source side chained advance on request
    dir_dst = 1'b0;
    do_preload(32'h220, 32'h0);
    do_load();
    chk("R9 source chained no move", ptr64(), 64'h220);
    do_adv();
    chk_reads("R7 source", 2, 49'h220, 1);
    chk("R7 source", ptr64(), 64'h280);

    // R4 misaligned
    do_preload(32'h108, 32'h0);
    do_load();
    chk("R4 no read", 64'(n_rd - b_rd), 64'd0);
    chk("R4 pulse", 64'(n_err - b_err), 64'd1);
    chk("R4 zero", {15'b0, buf_addr} | {34'b0, byte_size}, 64'h0);
    chk("R4 sticky", {63'b0, err_sticky}, 64'h1);
    do_preload(32'h50, 32'h0);
    chk("R2 clears sticky", {63'b0, err_sticky}, 64'h0);

    // R5 descriptor read error
    err_idx = 22;
    do_load();
    chk("R5 pulse", 64'(n_err - b_err), 64'd1);
    chk("R5 no done", 64'(n_done - b_done), 64'd0);
    chk("R5 zero", {15'b0, buf_addr} | {34'b0, byte_size}, 64'h0);
    chk("R5 pointer", ptr64(), 64'h50);
    chk("R5 sticky", {63'b0, err_sticky}, 64'h1);

    // R5 link read error after clean fetch
    dir_dst = 1'b1;
    err_idx = 128 + 16 + 4;
    do_preload(32'h240, 32'h0);
    do_load();
    chk("R5 link done", 64'(n_done - b_done), 64'd1);
    chk("R5 link err", 64'(n_err - b_err), 64'd1);
    chk("R5 link pointer", ptr64(), 64'h240);
    chk("R5 link sticky", {63'b0, err_sticky}, 64'h1);
    err_idx = -1;

    // R8 register mode
    reg_mode = 1'b1;
    reg_words = mk_desc(77, 1'b1, 1'b1);
    do_preload(32'h300, 32'h0);
    do_load();
    chk_fields("R8", reg_words);
    chk("R8 no read", 64'(n_rd - b_rd), 64'd0);
    chk("R8 no advance", ptr64(), 64'h300);
    chk("R8 no adv pulse", 64'(n_adv - b_adv), 64'd0);
    chk("R8 done", 64'(n_done - b_done), 64'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule